// File: doc/BRIEF.md
# Record-Framed Ingress Buffer With Whole-Record Discard

This block sits at the inbound edge of a protected device. An untrusted host pushes a word stream into it, one word per cycle. Each record in the stream begins with a word that carries a start marker and finishes with a word that carries an end marker. The handshake never changes with the buffer's state. Every word that is offered is acknowledged one cycle later, so an observer at the pins learns nothing about fill level, overflow or discard activity.

Internally the block keeps a circular store that tracks three positions: the write point, the start of the record now arriving, and the read point. A record becomes visible to the consumer only once its end word has been stored. A word that arrives when the store already holds its full capacity cancels the whole record. The words of that record already written are withdrawn by moving the write point back to the record's start. Every later word of the record is ignored until the next start marker. A sticky overflow flag tells the consumer that a record was lost, and the consumer clears it with a write-one-to-clear strobe.

The consumer side drains one committed word per cycle whenever its downstream store is not full. A level output rises when the number of held words, including those of a record still arriving, reaches a programmable threshold. The draining side uses it to ask for service.

Top module: `rec_ingress_fifo`

## Requirements
- R1: `in_ack` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low. This holds whatever the fill level, the receive state or the overflow flag.
- R2: No word of a record is delivered on the output until that record's end-marked word has been stored. Once it is stored, all of the record's words are delivered in arrival order with their marker bits.
- R3: Suppose a word is accepted for a record while the store holds DEPTH words, counting the stored words of that record. Then the word is not stored, every stored word of that record is withdrawn and never delivered, and `ovf_flag` is high from the next cycle.
- R4: After an overflow, each following word without a start marker is dropped, including an end-marked word. The fill level stays unchanged and nothing from that record is delivered.
- R5: A start-marked word ends the discard, and the record it opens is stored and delivered normally.
- R6: A cycle with `flag_wr` high and `flag_w1c` high clears `ovf_flag` on the next cycle. A cycle with `flag_wr` high and `flag_w1c` low leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R7: While committed words remain and `dst_full` is low, one word per cycle is removed. It appears on `out_data`/`out_sor`/`out_eor` with `out_valid` high in the following cycle. `out_valid` is low in every cycle that follows a cycle with `dst_full` high.
- R8: `level_hit` is high exactly when the held word count is at least `thresh_lvl`. The count covers committed words not yet removed plus stored words of the record still arriving.
- R9: A word without a start marker that arrives while no record is open is dropped. It neither changes the fill level nor sets the flag.
- R10: A start-marked word that arrives while a record is open withdraws that record's stored words without setting the flag, then starts a new record.
- R11: After reset the store is empty, and `ovf_flag`, `in_ack` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a word this cycle |
| in_data | input | DATA_W | Offered word payload |
| in_sor | input | 1 | Offered word opens a record |
| in_eor | input | 1 | Offered word closes a record |
| in_ack | output | 1 | Acknowledge, one cycle after each offered word |
| dst_full | input | 1 | Downstream store cannot take a word |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | DATA_W | Output word payload |
| out_sor | output | 1 | Output word opened its record |
| out_eor | output | 1 | Output word closed its record |
| thresh_lvl | input | AW+1 | Fill level at which `level_hit` rises |
| level_hit | output | 1 | Held word count is at or above `thresh_lvl` |
| flag_wr | input | 1 | Consumer write strobe for the overflow flag |
| flag_w1c | input | 1 | Write data bit; 1 clears the flag |
| ovf_flag | output | 1 | Sticky indication that a record was discarded |

## Verification
A rollback pointer that was wrong would show up at the output a few cycles after the next end-marked word. It would appear either as stray words from the cancelled record or as missing words from the one before it. The bench therefore compares the full delivered word list after every scenario. A discard state that fails to clear would drop the next valid record and show no output at all. A flag fault shows up on `ovf_flag` one cycle after the offending word. A commit point that moved too early would deliver half records, and the bench catches this by idling mid-record with the drain open. An acknowledge that tracked fullness would show on `in_ack` one cycle after a word sent into a full store. The bench checks that on every word sent.

// File: rtl/rif_pkg.sv
package rif_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BODY = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  // Distance from b to a on a pointer ring of pw bits.
  function automatic logic [31:0] ptr_span(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (a - b) & mask;
  endfunction

  // True when a span equals the store capacity.
  function automatic logic span_full(input logic [31:0] span,
                                     input int unsigned depth);
    return span == 32'(depth);
  endfunction

  // Threshold compare used for the level output.
  function automatic logic at_level(input logic [31:0] span,
                                    input logic [31:0] lvl);
    return span >= lvl;
  endfunction

endpackage

// File: rtl/rif_store.sv
module rif_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_word;
  end

  assign rd_word = cells[rd_idx];

endmodule

// File: rtl/rif_rx.sv
module rif_rx
  import rif_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sor,
  input  logic          in_eor,
  input  logic [PW-1:0] rd_ptr,
  output logic          in_ack,
  output logic          wr_fire,
  output logic [AW-1:0] wr_idx,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] cmt_ptr,
  output logic          ovf_evt,
  output logic          commit_evt,
  output logic          restart_evt,
  output rx_state_e     rx_state
);

  logic [PW-1:0] base_ptr;
  logic [PW-1:0] next_ptr;
  logic          accept;
  logic          full_at_base;

  // A start marker always rewinds to the commit point; otherwise continue.
  assign base_ptr     = in_sor ? cmt_ptr : wr_ptr;
  assign next_ptr     = base_ptr + PW'(1);
  assign full_at_base = span_full(ptr_span(32'(base_ptr), 32'(rd_ptr), PW), DEPTH);
  assign accept       = in_valid && (in_sor || (rx_state == RX_BODY));
  assign ovf_evt      = accept && full_at_base;
  assign wr_fire      = accept && !full_at_base;
  assign commit_evt   = wr_fire && in_eor;
  assign restart_evt  = in_valid && in_sor && (rx_state == RX_BODY);
  assign wr_idx       = base_ptr[AW-1:0];

  // Acknowledge depends on the offer alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ack <= 1'b0;
    else        in_ack <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rx_state <= RX_IDLE;
    end else if (ovf_evt) begin
      wr_ptr   <= cmt_ptr;
      rx_state <= RX_DROP;
    end else if (wr_fire) begin
      wr_ptr <= next_ptr;
      if (in_eor) begin
        cmt_ptr  <= next_ptr;
        rx_state <= RX_IDLE;
      end else begin
        rx_state <= RX_BODY;
      end
    end
  end

endmodule

// File: rtl/rif_flag.sv
module rif_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic flag_wr,
  input  logic flag_w1c,
  output logic ovf_flag
);

  logic clr_req;
  assign clr_req = flag_wr && flag_w1c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
    else if (clr_req) ovf_flag <= 1'b0;
  end

endmodule

// File: rtl/rif_drain.sv
module rif_drain #(
  parameter int WORD_W = 18,
  parameter int AW     = 3,
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     cmt_ptr,
  input  logic              dst_full,
  input  logic [WORD_W-1:0] rd_word,
  output logic [PW-1:0]     rd_ptr,
  output logic [AW-1:0]     rd_idx,
  output logic              pop_evt,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);

  assign pop_evt = (rd_ptr != cmt_ptr) && !dst_full;
  assign rd_idx  = rd_ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= pop_evt;
      if (pop_evt) begin
        rd_ptr   <= rd_ptr + PW'(1);
        out_word <= rd_word;
      end
    end
  end

endmodule

// File: rtl/rec_ingress_fifo.sv
module rec_ingress_fifo
  import rif_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sor,
  input  logic              in_eor,
  output logic              in_ack,
  input  logic              dst_full,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sor,
  output logic              out_eor,
  input  logic [PW-1:0]     thresh_lvl,
  output logic              level_hit,
  input  logic              flag_wr,
  input  logic              flag_w1c,
  output logic              ovf_flag
);

  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     cmt_ptr;
  logic [PW-1:0]     rd_ptr;
  logic [AW-1:0]     wr_idx;
  logic [AW-1:0]     rd_idx;
  logic              wr_fire;
  logic              ovf_evt;
  logic              commit_evt;
  logic              restart_evt;
  logic              pop_evt;
  rx_state_e         rx_state;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] out_word;
  logic [31:0]       fill_span;

  assign wr_word = {in_sor, in_eor, in_data};

  rif_rx #(.DEPTH(DEPTH), .AW(AW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sor      (in_sor),
    .in_eor      (in_eor),
    .rd_ptr      (rd_ptr),
    .in_ack      (in_ack),
    .wr_fire     (wr_fire),
    .wr_idx      (wr_idx),
    .wr_ptr      (wr_ptr),
    .cmt_ptr     (cmt_ptr),
    .ovf_evt     (ovf_evt),
    .commit_evt  (commit_evt),
    .restart_evt (restart_evt),
    .rx_state    (rx_state)
  );

  rif_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_idx  (wr_idx),
    .wr_word (wr_word),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  rif_drain #(.WORD_W(WORD_W), .AW(AW)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmt_ptr   (cmt_ptr),
    .dst_full  (dst_full),
    .rd_word   (rd_word),
    .rd_ptr    (rd_ptr),
    .rd_idx    (rd_idx),
    .pop_evt   (pop_evt),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  rif_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_evt  (ovf_evt),
    .flag_wr  (flag_wr),
    .flag_w1c (flag_w1c),
    .ovf_flag (ovf_flag)
  );

  assign out_sor   = out_word[WORD_W-1];
  assign out_eor   = out_word[WORD_W-2];
  assign out_data  = out_word[DATA_W-1:0];
  assign fill_span = ptr_span(32'(wr_ptr), 32'(rd_ptr), PW);
  assign level_hit = at_level(fill_span, 32'(thresh_lvl));

endmodule

// File: rtl/rif_checks.sv
module rif_checks
  import rif_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  localparam int PW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sor,
  input logic          in_ack,
  input logic          dst_full,
  input logic          out_valid,
  input logic          flag_wr,
  input logic          flag_w1c,
  input logic          ovf_flag,
  input logic          ovf_evt,
  input logic          commit_evt,
  input rx_state_e     rx_state,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] cmt_ptr,
  input logic [PW-1:0] rd_ptr
);

  assert_ack_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> in_ack);

  assert_ack_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !in_ack);

  assert_commit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (rx_state == RX_IDLE) && (wr_ptr == cmt_ptr));

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  assert_rollback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (wr_ptr == cmt_ptr) && (rx_state == RX_DROP));

  assert_drop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == RX_DROP && in_valid && !in_sor) |=> $stable(wr_ptr));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_w1c && !ovf_evt) |=> !ovf_flag);

  assert_no_pop_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_full |=> !out_valid);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_span(32'(wr_ptr), 32'(rd_ptr), PW) <= 32'(DEPTH));

  assert_read_behind_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_span(32'(cmt_ptr), 32'(rd_ptr), PW) <= ptr_span(32'(wr_ptr), 32'(rd_ptr), PW));

  assert_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == RX_IDLE && in_valid && !in_sor && !flag_wr)
      |=> $stable(wr_ptr) && $stable(ovf_flag));

endmodule

bind rec_ingress_fifo rif_checks #(.DEPTH(DEPTH), .AW(AW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sor     (in_sor),
  .in_ack     (in_ack),
  .dst_full   (dst_full),
  .out_valid  (out_valid),
  .flag_wr    (flag_wr),
  .flag_w1c   (flag_w1c),
  .ovf_flag   (ovf_flag),
  .ovf_evt    (ovf_evt),
  .commit_evt (commit_evt),
  .rx_state   (rx_state),
  .wr_ptr     (wr_ptr),
  .cmt_ptr    (cmt_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/sim_rec_ingress_fifo.sv
module sim_rec_ingress_fifo;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int PW     = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_sor = 1'b0;
  logic              in_eor = 1'b0;
  logic              in_ack;
  logic              dst_full = 1'b1;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_sor;
  logic              out_eor;
  logic [PW-1:0]     thresh_lvl = PW'(4);
  logic              level_hit;
  logic              flag_wr = 1'b0;
  logic              flag_w1c = 1'b0;
  logic              ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DATA_W+1:0] got_q[$];
  logic [DATA_W+1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  rec_ingress_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sor(in_sor), .in_eor(in_eor), .in_ack(in_ack), .dst_full(dst_full),
    .out_valid(out_valid), .out_data(out_data), .out_sor(out_sor),
    .out_eor(out_eor), .thresh_lvl(thresh_lvl), .level_hit(level_hit),
    .flag_wr(flag_wr), .flag_w1c(flag_w1c), .ovf_flag(ovf_flag)
  );

  // Output capture away from the active edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) got_q.push_back({out_sor, out_eor, out_data});
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_word(input logic [DATA_W-1:0] d, input bit s, input bit e);
    exp_q.push_back({s, e, d});
  endtask

  task automatic compare_out(input string req);
    chk(got_q.size() == exp_q.size(), req, "delivered word count",
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, "delivered word", int'(got_q[i]), int'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic send(input logic [DATA_W-1:0] d, input bit s, input bit e);
    in_valid = 1'b1;
    in_data  = d;
    in_sor   = s;
    in_eor   = e;
    @(negedge clk);
    chk(in_ack == 1'b1, "R1", "ack after offered word", int'(in_ack), 1);
    in_valid = 1'b0;
    in_sor   = 1'b0;
    in_eor   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    chk(ovf_flag == 1'b0, "R11", "flag after reset", int'(ovf_flag), 0);
    chk(in_ack == 1'b0, "R11", "ack after reset", int'(in_ack), 0);
    chk(level_hit == 1'b0, "R11", "level at thresh 4 when empty", int'(level_hit), 0);
  endtask

  task automatic t_commit_gate;
    dst_full = 1'b0;
    send(16'h0A00, 1, 0);
    send(16'h0A01, 0, 0);
    idle(4);
    chk(got_q.size() == 0, "R2", "words visible before end marker", got_q.size(), 0);
    send(16'h0A02, 0, 1);
    send(16'h0B00, 1, 1);
    idle(8);
    expect_word(16'h0A00, 1, 0);
    expect_word(16'h0A01, 0, 0);
    expect_word(16'h0A02, 0, 1);
    expect_word(16'h0B00, 1, 1);
    compare_out("R2");
    idle(1);
    chk(in_ack == 1'b0, "R1", "ack low when idle", int'(in_ack), 0);
  endtask

  task automatic t_level;
    dst_full   = 1'b1;
    thresh_lvl = PW'(3);
    send(16'h0C00, 1, 0);
    send(16'h0C01, 0, 0);
    chk(level_hit == 1'b0, "R8", "level with 2 held of 3", int'(level_hit), 0);
    send(16'h0C02, 0, 1);
    chk(level_hit == 1'b1, "R8", "level with 3 held of 3", int'(level_hit), 1);
    dst_full = 1'b0;
    idle(6);
    chk(level_hit == 1'b0, "R8", "level after drain", int'(level_hit), 0);
    expect_word(16'h0C00, 1, 0);
    expect_word(16'h0C01, 0, 0);
    expect_word(16'h0C02, 0, 1);
    compare_out("R7");
  endtask

  task automatic t_overflow;
    dst_full = 1'b1;
    send(16'h0100, 1, 0);
    for (int i = 1; i < 4; i++) send(16'h0100 + 16'(i), 0, 0);
    send(16'h0104, 0, 1);
    send(16'h0200, 1, 0);
    send(16'h0201, 0, 0);
    send(16'h0202, 0, 0);
    chk(ovf_flag == 1'b0, "R3", "flag before overflow", int'(ovf_flag), 0);
    send(16'h0203, 0, 0);
    chk(ovf_flag == 1'b1, "R3", "flag after overflow", int'(ovf_flag), 1);
    thresh_lvl = PW'(5);
    #1;
    chk(level_hit == 1'b1, "R3", "fill rolled back to 5 (>=5)", int'(level_hit), 1);
    thresh_lvl = PW'(6);
    #1;
    chk(level_hit == 1'b0, "R3", "fill rolled back to 5 (<6)", int'(level_hit), 0);
    send(16'h0204, 0, 0);
    send(16'h0205, 0, 1);
    chk(level_hit == 1'b0, "R4", "discarded words not stored", int'(level_hit), 0);
    chk(ovf_flag == 1'b1, "R4", "flag held during discard", int'(ovf_flag), 1);
    send(16'h0300, 1, 0);
    send(16'h0301, 0, 1);
    thresh_lvl = PW'(7);
    #1;
    chk(level_hit == 1'b1, "R5", "new record stored after discard", int'(level_hit), 1);
    dst_full = 1'b1;
    idle(2);
    chk(got_q.size() == 0, "R7", "no output while downstream full", got_q.size(), 0);
    dst_full = 1'b0;
    idle(12);
    expect_word(16'h0100, 1, 0);
    for (int i = 1; i < 4; i++) expect_word(16'h0100 + 16'(i), 0, 0);
    expect_word(16'h0104, 0, 1);
    expect_word(16'h0300, 1, 0);
    expect_word(16'h0301, 0, 1);
    compare_out("R5");
  endtask

  task automatic t_flag_clear;
    flag_wr = 1'b1;
    flag_w1c = 1'b0;
    @(negedge clk);
    flag_wr = 1'b0;
    chk(ovf_flag == 1'b1, "R6", "write of 0 keeps flag", int'(ovf_flag), 1);
    flag_wr = 1'b1;
    flag_w1c = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    flag_w1c = 1'b0;
    chk(ovf_flag == 1'b0, "R6", "write of 1 clears flag", int'(ovf_flag), 0);
    // Overflow in the same cycle as a clear keeps the flag.
    dst_full = 1'b1;
    send(16'h0400, 1, 0);
    for (int i = 1; i < DEPTH; i++) send(16'h0400 + 16'(i), 0, 0);
    flag_wr = 1'b1;
    flag_w1c = 1'b1;
    send(16'h0408, 0, 0);
    flag_wr = 1'b0;
    flag_w1c = 1'b0;
    chk(ovf_flag == 1'b1, "R6", "overflow wins over clear", int'(ovf_flag), 1);
    thresh_lvl = PW'(1);
    #1;
    chk(level_hit == 1'b0, "R3", "whole record withdrawn", int'(level_hit), 0);
    dst_full = 1'b0;
    idle(6);
    compare_out("R3");
    flag_wr = 1'b1;
    flag_w1c = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    flag_w1c = 1'b0;
  endtask

  task automatic t_stray;
    thresh_lvl = PW'(1);
    send(16'h0E00, 0, 0);
    send(16'h0E01, 0, 1);
    chk(level_hit == 1'b0, "R9", "stray words not stored", int'(level_hit), 0);
    chk(ovf_flag == 1'b0, "R9", "stray words leave flag", int'(ovf_flag), 0);
    idle(4);
    compare_out("R9");
  endtask

  task automatic t_restart;
    dst_full = 1'b0;
    send(16'h0500, 1, 0);
    send(16'h0501, 0, 0);
    send(16'h0600, 1, 0);
    send(16'h0601, 0, 1);
    idle(6);
    chk(ovf_flag == 1'b0, "R10", "restart leaves flag", int'(ovf_flag), 0);
    expect_word(16'h0600, 1, 0);
    expect_word(16'h0601, 0, 1);
    compare_out("R10");
  endtask

  initial begin
    #(CLK_P * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_commit_gate();
    t_level();
    t_overflow();
    t_flag_clear();
    t_stray();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule